// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous 64K x 16 Static RAM

This block connects a clocked host to an external asynchronous static RAM of 65,536 words by 16 bits. The host posts one request at a time over a valid/ready handshake. A request carries a 16-bit word address, 16 bits of write data, a two-bit lane mask and a read/write flag. The controller turns each request into a timed sequence on the memory's active-low controls: chip select, output enable, write strobe and one enable per byte lane. It also drives a bidirectional data bus, which is split here into an output value, a drive enable and an input value.

The length of each phase is counted in clock cycles. The counts come from nanosecond timing values and the clock period in picoseconds, each rounded up to a whole cycle. At a 10 ns clock, the read access, the write pulse and the write cycle each round to one cycle. A write opens with one setup cycle, in which address, chip select and lane enables are driven with the strobe still high. The strobe then goes low while data is driven. The strobe rises first to end the write, and data and address stay on the bus for at least one more cycle before the bus is released. Each read is followed by a cycle with every control high and the drivers off, so a later write can never collide with data the memory is still driving.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, reqReady is 1, sramCeN, sramOeN and sramWeN are 1, both sramBeN bits are 1, sramDqOe is 0 and rdValid is 0.
- R2: A read accepted with a non-zero mask holds sramCeN=0, sramOeN=0 and sramWeN=1 for RD_ACCESS_CYC cycles, starting the cycle after acceptance. During those cycles sramAddr equals the request address. sramBeN[0] (data bits 7..0) is low only when reqMask[0]=1, and sramBeN[1] (bits 15..8) is low only when reqMask[1]=1.
- R3: Read data is captured at the edge that ends the last access cycle. rdValid is high for exactly the following cycle. In rdData, a lane whose mask bit is 0 reads as zero.
- R4: After every read access there is one cycle with all controls high and sramDqOe=0. reqReady returns only after that cycle.
- R5: A write accepted with a non-zero mask runs in three phases, starting the cycle after acceptance. First, one setup cycle with sramCeN=0, sramWeN=1 and sramDqOe=0. Next, WR_PULSE_CYC cycles with sramWeN=0 and sramDqOe=1. Last, max(1, WR_CYCLE_CYC-WR_PULSE_CYC-1) hold cycles with sramWeN=1 while sramCeN=0 and sramDqOe=1. sramAddr equals the request address throughout, and the lane enables follow the mask as in R2.
- R6: A write changes only the byte lanes selected by its mask. The other lane of the addressed word keeps its old value, as seen by a later read.
- R7: sramDqOe is never 1 while sramOeN is 0, and sramOeN stays 1 during every write phase.
- R8: A request with mask 00 never lowers sramCeN, and reqReady stays 1. As a read, it gives rdValid in the next cycle with rdData=0. As a write, it leaves memory unchanged.
- R9: reqReady is 0 from the edge that accepts a non-zero-mask request until its last phase ends. A request is taken only on an edge where reqValid and reqReady are both 1.
- R10: With a 10,000 ps clock, the default counts derived from the timing values are RD_ACCESS_CYC=1, WR_PULSE_CYC=1 and WR_CYCLE_CYC=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller idle and able to accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane select; bit0 = bits 7..0, bit1 = bits 15..8 |
| rdValid | output | 1 | One-cycle pulse marking rdData valid |
| rdData | output | 16 | Registered read data, unselected lanes zero |
| sramAddr | output | 16 | Memory address lines |
| sramCeN | output | 1 | Chip select, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write strobe, active low |
| sramBeN | output | 2 | Lane enables, active low; bit0 lower, bit1 upper |
| sramDqOut | output | 16 | Data driven toward memory |
| sramDqOe | output | 1 | 1 = controller drives the data bus |
| sramDqIn | input | 16 | Data seen on the bus |

## Verification
The bench drives full-word writes, writes to a single lane, mask-00 requests of both kinds and read-back at the lowest and highest addresses. It follows these with a pseudo-random mix of reads and writes in which reads and writes follow one another directly. Single-lane writes followed by full reads show whether the unselected lane is preserved. The memory model places a fixed non-zero pattern on unselected lanes, which exposes missing read masking. Back-to-back read-then-write traffic shows whether the turnaround cycle is kept. The mask-00 requests show whether chip select is held off and whether the handshake stays open.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_TURN,
    PH_WSETUP,
    PH_WPULSE,
    PH_WHOLD
  } phase_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;     // latch the request fields
    logic capture;  // sample bus data into rdData
    logic clear;    // zero rdData (empty-mask read)
    logic ceN;
    logic oeN;
    logic weN;
    logic laneOn;   // lane enables follow the latched mask
    logic drive;    // drive the data bus
  } strobe_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/sram_lane_fsm.sv
`timescale 1ns/1ps
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int MASK_W  = 2,
  parameter int RD_N    = 1,
  parameter int PULSE_N = 1,
  parameter int HOLD_N  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [MASK_W-1:0] reqMask,
  output logic              reqReady,
  output logic              rdValid,
  output strobe_t           stb
);

  localparam int MAX_N = (RD_N > PULSE_N) ? ((RD_N > HOLD_N) ? RD_N : HOLD_N)
                                          : ((PULSE_N > HOLD_N) ? PULSE_N : HOLD_N);
  localparam int CNT_W = (MAX_N < 2) ? 1 : $clog2(MAX_N);

  phase_e phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic accept;
  logic maskEmpty;

  assign maskEmpty = (reqMask == '0);
  assign reqReady  = (phase == PH_IDLE);
  assign accept    = reqValid && reqReady;

  always_comb begin
    phaseNext   = phase;
    cntNext     = cnt;
    stb         = '0;
    stb.ceN     = 1'b1;
    stb.oeN     = 1'b1;
    stb.weN     = 1'b1;
    unique case (phase)
      PH_IDLE: begin
        stb.load = accept;
        cntNext  = '0;
        if (accept) begin
          if (maskEmpty)     stb.clear = !reqWrite;
          else if (reqWrite) phaseNext = PH_WSETUP;
          else               phaseNext = PH_READ;
        end
      end
      PH_READ: begin
        stb.ceN    = 1'b0;
        stb.oeN    = 1'b0;
        stb.laneOn = 1'b1;
        if (cnt == CNT_W'(RD_N - 1)) begin
          stb.capture = 1'b1;
          cntNext     = '0;
          phaseNext   = PH_TURN;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      PH_TURN: begin
        phaseNext = PH_IDLE;
      end
      PH_WSETUP: begin
        stb.ceN    = 1'b0;
        stb.laneOn = 1'b1;
        phaseNext  = PH_WPULSE;
      end
      PH_WPULSE: begin
        stb.ceN    = 1'b0;
        stb.weN    = 1'b0;
        stb.laneOn = 1'b1;
        stb.drive  = 1'b1;
        if (cnt == CNT_W'(PULSE_N - 1)) begin
          cntNext   = '0;
          phaseNext = PH_WHOLD;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      PH_WHOLD: begin
        stb.ceN    = 1'b0;
        stb.laneOn = 1'b1;
        stb.drive  = 1'b1;
        if (cnt == CNT_W'(HOLD_N - 1)) begin
          cntNext   = '0;
          phaseNext = PH_IDLE;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      rdValid <= 1'b0;
    end else begin
      phase   <= phaseNext;
      cnt     <= cntNext;
      rdValid <= stb.capture || stb.clear;
    end
  end

  // R3: the read-valid pulse lasts a single cycle
  a_r3_rdvalid_single: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R9: accepting a non-empty request closes the handshake
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !maskEmpty) |=> !reqReady);

endmodule

// File: rtl/sram_lane_dp.sv
`timescale 1ns/1ps
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [DATA_W/8-1:0]    reqMask,
  output logic [DATA_W-1:0]      rdData,
  output logic [ADDR_W-1:0]      sramAddr,
  output logic                   sramCeN,
  output logic                   sramOeN,
  output logic                   sramWeN,
  output logic [DATA_W/8-1:0]    sramBeN,
  output logic [DATA_W-1:0]      sramDqOut,
  output logic                   sramDqOe,
  input  logic [DATA_W-1:0]      sramDqIn
);

  localparam int LANE_N = DATA_W / 8;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [LANE_N-1:0] maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      maskReg <= '0;
    end else if (stb.load) begin
      addrReg <= reqAddr;
      dataReg <= reqWdata;
      maskReg <= reqMask;
    end
  end

  assign sramAddr  = addrReg;
  assign sramDqOut = dataReg;
  assign sramDqOe  = stb.drive;
  assign sramCeN   = stb.ceN;
  assign sramOeN   = stb.oeN;
  assign sramWeN   = stb.weN;

  for (genvar g = 0; g < LANE_N; g++) begin : gLane
    assign sramBeN[g] = !(stb.laneOn && maskReg[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdData[8*g +: 8] <= '0;
      end else if (stb.clear) begin
        rdData[8*g +: 8] <= '0;
      end else if (stb.capture) begin
        rdData[8*g +: 8] <= maskReg[g] ? sramDqIn[8*g +: 8] : 8'h00;
      end
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int CLK_PS        = 10000,
  parameter int T_PULSE_PS    = 8000,
  parameter int T_WCYCLE_PS   = 10000,
  parameter int T_ACCESS_PS   = 10000,
  parameter int WR_PULSE_CYC  = sram_lane_pkg::cdiv(T_PULSE_PS, CLK_PS),
  parameter int WR_CYCLE_CYC  = sram_lane_pkg::cdiv(T_WCYCLE_PS, CLK_PS),
  parameter int RD_ACCESS_CYC = sram_lane_pkg::cdiv(T_ACCESS_PS, CLK_PS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqMask,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic [ADDR_W-1:0]   sramAddr,
  output logic                sramCeN,
  output logic                sramOeN,
  output logic                sramWeN,
  output logic [DATA_W/8-1:0] sramBeN,
  output logic [DATA_W-1:0]   sramDqOut,
  output logic                sramDqOe,
  input  logic [DATA_W-1:0]   sramDqIn
);

  localparam int LANE_N   = DATA_W / 8;
  localparam int RD_N     = (RD_ACCESS_CYC < 1) ? 1 : RD_ACCESS_CYC;
  localparam int PULSE_N  = (WR_PULSE_CYC < 1) ? 1 : WR_PULSE_CYC;
  localparam int HOLD_RAW = WR_CYCLE_CYC - PULSE_N - 1;
  localparam int HOLD_N   = (HOLD_RAW < 1) ? 1 : HOLD_RAW;

  strobe_t stb;

  sram_lane_fsm #(
    .MASK_W (LANE_N),
    .RD_N   (RD_N),
    .PULSE_N(PULSE_N),
    .HOLD_N (HOLD_N)
  ) uFsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqMask (reqMask),
    .reqReady(reqReady),
    .rdValid (rdValid),
    .stb     (stb)
  );

  sram_lane_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqMask  (reqMask),
    .rdData   (rdData),
    .sramAddr (sramAddr),
    .sramCeN  (sramCeN),
    .sramOeN  (sramOeN),
    .sramWeN  (sramWeN),
    .sramBeN  (sramBeN),
    .sramDqOut(sramDqOut),
    .sramDqOe (sramDqOe),
    .sramDqIn (sramDqIn)
  );

  // R7: no bus drive while the memory output is enabled
  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    sramDqOe |-> sramOeN);

  // R5: a low strobe sits inside chip select with outputs off
  a_r5_strobe_inside_select: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (!sramCeN && sramOeN));

  // R5: strobe rises before the data bus is released
  a_r5_data_held_at_end: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sramWeN) && !sramCeN) |-> sramDqOe);

  // R4: a read access is followed by a quiet turnaround cycle
  a_r4_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramOeN) |-> (sramCeN && !sramDqOe && !reqReady));

  // R8: an empty-mask request never selects the memory
  a_r8_empty_no_select: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqMask == '0) |=> (sramCeN && reqReady));

  // R10: default counts at a 10 ns clock
  initial begin
    if (CLK_PS == 10000 && T_PULSE_PS == 8000 && T_WCYCLE_PS == 10000 && T_ACCESS_PS == 10000)
      a_r10_default_counts: assert (WR_PULSE_CYC == 1 && WR_CYCLE_CYC == 1 && RD_ACCESS_CYC == 1);
  end

endmodule

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;

  localparam int CLK_PS = 10000;
  // counts worked out from the timing values, independent of the design
  localparam int E_RD   = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int E_PW   = (8000 + CLK_PS - 1) / CLK_PS;
  localparam int E_WC   = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int E_HOLD = (E_WC - E_PW - 1 < 1) ? 1 : (E_WC - E_PW - 1);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        rdValid;
  logic [15:0] rdData;
  logic [15:0] sramAddr;
  logic        sramCeN, sramOeN, sramWeN;
  logic [1:0]  sramBeN;
  logic [15:0] sramDqOut;
  logic        sramDqOe;
  logic [15:0] sramDqIn;

  always #5 clk = ~clk;

  sram_lane_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rdValid(rdValid), .rdData(rdData), .sramAddr(sramAddr), .sramCeN(sramCeN),
    .sramOeN(sramOeN), .sramWeN(sramWeN), .sramBeN(sramBeN), .sramDqOut(sramDqOut),
    .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  int checks = 0;
  int failures = 0;
  bit running = 1'b0;

  typedef struct {
    bit [7:0]    ctl;     // {ready, ceN, oeN, weN, beN[1:0], drive, rdValid}
    bit          chkAddr;
    logic [15:0] addr;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  logic [15:0] rdQ[$];
  logic [15:0] gold[int];
  logic [15:0] mem[int];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic exp_t mkE(input bit [7:0] c, input bit ca, input logic [15:0] a, input string t);
    exp_t e;
    e.ctl = c; e.chkAddr = ca; e.addr = a; e.tag = t;
    return e;
  endfunction

  function automatic logic [15:0] rdMem(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction

  function automatic logic [15:0] rdGold(input logic [15:0] a);
    return gold.exists(int'(a)) ? gold[int'(a)] : 16'h0000;
  endfunction

  // memory model on the far side of the bus
  always @* begin
    sramDqIn = 16'hC3C3;
    if (!sramCeN && !sramOeN && sramWeN) begin
      if (!sramBeN[0]) sramDqIn[7:0]  = rdMem(sramAddr)[7:0];
      if (!sramBeN[1]) sramDqIn[15:8] = rdMem(sramAddr)[15:8];
    end
  end

  // cycle-by-cycle reference, compared mid-cycle
  always @(negedge clk) begin
    if (rstN && running) begin
      exp_t e;
      bit [7:0] act;
      logic [15:0] w;
      e = (expQ.size() != 0) ? expQ.pop_front() : mkE(8'b1_1_1_1_11_0_0, 1'b0, '0, "R9 idle");
      act = {reqReady, sramCeN, sramOeN, sramWeN, sramBeN, sramDqOe, rdValid};
      check(act == e.ctl, e.tag, {24'h0, act}, {24'h0, e.ctl});
      if (e.chkAddr) check(sramAddr == e.addr, {e.tag, " addr"}, {16'h0, sramAddr}, {16'h0, e.addr});
      check(!(sramDqOe && !sramOeN), "R7 contention", {31'h0, sramDqOe}, 32'h0);
      if (rdValid) begin
        logic [15:0] er;
        er = (rdQ.size() != 0) ? rdQ.pop_front() : 16'hxxxx;
        check(rdData === er, "R3 R6 read data", {16'h0, rdData}, {16'h0, er});
      end
      if (!sramCeN && !sramWeN) begin
        w = rdMem(sramAddr);
        if (!sramBeN[0]) w[7:0]  = sramDqOut[7:0];
        if (!sramBeN[1]) w[15:8] = sramDqOut[15:8];
        mem[int'(sramAddr)] = w;
      end
      if (reqValid && reqReady) begin
        bit [1:0] be;
        be = ~reqMask;
        if (reqMask == 2'b00) begin
          if (!reqWrite) begin
            expQ.push_back(mkE(8'b1_1_1_1_11_0_1, 1'b0, '0, "R8 empty read"));
            rdQ.push_back(16'h0000);
          end
        end else if (reqWrite) begin
          logic [15:0] g;
          expQ.push_back(mkE({1'b0, 1'b0, 1'b1, 1'b1, be, 1'b0, 1'b0}, 1'b1, reqAddr, "R5 setup"));
          for (int i = 0; i < E_PW; i++)
            expQ.push_back(mkE({1'b0, 1'b0, 1'b1, 1'b0, be, 1'b1, 1'b0}, 1'b1, reqAddr, "R5 pulse"));
          for (int i = 0; i < E_HOLD; i++)
            expQ.push_back(mkE({1'b0, 1'b0, 1'b1, 1'b1, be, 1'b1, 1'b0}, 1'b1, reqAddr, "R5 hold"));
          g = rdGold(reqAddr);
          if (reqMask[0]) g[7:0]  = reqWdata[7:0];
          if (reqMask[1]) g[15:8] = reqWdata[15:8];
          gold[int'(reqAddr)] = g;
        end else begin
          logic [15:0] d;
          for (int i = 0; i < E_RD; i++)
            expQ.push_back(mkE({1'b0, 1'b0, 1'b0, 1'b1, be, 1'b0, 1'b0}, 1'b1, reqAddr, "R2 access"));
          expQ.push_back(mkE(8'b0_1_1_1_11_0_1, 1'b0, '0, "R4 turnaround"));
          d = rdGold(reqAddr);
          if (!reqMask[0]) d[7:0]  = 8'h00;
          if (!reqMask[1]) d[15:8] = 8'h00;
          rdQ.push_back(d);
        end
      end
    end
  end

  task automatic doReq(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    do begin
      @(posedge clk); #2;
    end while (!reqReady);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    @(posedge clk); #2;
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({reqReady, sramCeN, sramOeN, sramWeN, sramBeN, sramDqOe, rdValid} == 8'b1_1_1_1_11_0_0,
          "R1 reset state", {24'h0, reqReady, sramCeN, sramOeN, sramWeN, sramBeN, sramDqOe, rdValid},
          32'h000000FC);
    check(E_RD == 1 && E_PW == 1 && E_WC == 1, "R10 counts", E_RD, 32'd1);
    @(posedge clk); #2;
    rstN = 1'b1;
    running = 1'b1;
    // full-word writes at the address extremes
    doReq(1'b1, 16'h0000, 16'hA1B2, 2'b11);
    doReq(1'b1, 16'hFFFF, 16'h5C6D, 2'b11);
    doReq(1'b0, 16'h0000, 16'h0000, 2'b11);
    doReq(1'b0, 16'hFFFF, 16'h0000, 2'b11);
    // single-lane writes keep the other lane (R6)
    doReq(1'b1, 16'h1234, 16'h1111, 2'b11);
    doReq(1'b1, 16'h1234, 16'hEE77, 2'b01);
    doReq(1'b0, 16'h1234, 16'h0000, 2'b11);
    doReq(1'b1, 16'h1234, 16'h99EE, 2'b10);
    doReq(1'b0, 16'h1234, 16'h0000, 2'b11);
    // single-lane reads: other lane reads zero (R3)
    doReq(1'b0, 16'h1234, 16'h0000, 2'b01);
    doReq(1'b0, 16'h1234, 16'h0000, 2'b10);
    // empty-mask requests (R8)
    doReq(1'b1, 16'h1234, 16'hFFFF, 2'b00);
    doReq(1'b0, 16'h1234, 16'h0000, 2'b00);
    doReq(1'b0, 16'h1234, 16'h0000, 2'b11);
    // read directly followed by write (R4, R7)
    doReq(1'b0, 16'h0000, 16'h0000, 2'b11);
    doReq(1'b1, 16'h0000, 16'h0F0F, 2'b11);
    doReq(1'b0, 16'h0000, 16'h0000, 2'b11);
    // pseudo-random mix on a small address set
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      doReq(lfsr[0], {13'h0, lfsr[3:1]}, {lfsr[7:0], lfsr[15:8]}, lfsr[5:4]);
    end
    repeat (6) @(posedge clk);
    check(expQ.size() == 0 && rdQ.size() == 0, "R3 R9 drained", expQ.size() + rdQ.size(), 32'h0);
    finishRun();
  end

  initial begin
    #500000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

endmodule